// File: doc/BRIEF.md
# Serial EEPROM Slave (512 bytes, SPI mode 0)

This block is an SPI slave that behaves like a small serial EEPROM. It holds a 512-byte array, a status register and a write-enable flag. It runs from a fast system clock and oversamples the serial lines. A host drops chip select, shifts in an 8-bit command and, for array access, one address byte. It then either streams data out or streams data in.

The array needs nine address bits but the command carries only one address byte. The ninth bit therefore rides in bit 3 of the read and write command bytes. Command decode ignores that bit when it matches the opcode, and keeps it as the top address bit.

Array writes collect into a page buffer. They reach the array only when chip select rises on a byte boundary. A busy interval follows each commit, and during it only status reads are served. The block-protect field of the status register fences off the top part of the array.

Top module: `spi_eeprom`

## Requirements
- R1: After reset, `miso` is low and a status read returns 0x00.
- R2: Command 0x06 sets the write-enable flag, which is status bit 1. Command 0x04 clears it.
- R3: Read is command 0x03 or 0x0B, followed by an address byte A[7:0]. Bit 3 of the command is A8. Data is returned MSB first. It is sampled on rising SCLK and shifted out on falling SCLK, with the first bit valid before the first rising edge after the address byte.
- R4: A read keeps returning consecutive addresses for as long as chip select stays low. After address 511 it continues at address 0.
- R5: Data write (0x02 or 0x0A, bit 3 being A8) and status write (0x01) have no effect unless the write-enable flag is set. Rejected commands leave the status at its old value and leave the array unchanged.
- R6: Write data bytes fill the 8-byte page that holds the start address. The byte offset wraps from 7 back to 0 inside that page.
- R7: A write commits only if chip select rises after a whole number of bytes, with at least one data byte. On a partial final byte the whole command is dropped, and the enable flag is kept.
- R8: A commit sets the busy flag (status bit 0) for BUSY_CYCLES clocks. The write-enable flag clears when busy clears.
- R9: While busy, every command other than status read (0x05) is ignored. A read returns zeros, and 0x04 does not clear the enable flag.
- R10: A status write stores bit 7 (protect-enable flag) and bits 4:2 (protect level BP). Bits 6:5 read as 0. Bits 1:0 are read-only.
- R11: With protect level BP = n, where n is non-zero, the top 512 >> (7 - n) bytes are protected. So n = 1 covers 0x1F8-0x1FF and n = 7 covers the whole array. Page writes there are dropped, but still go through the busy interval.
- R12: Unknown command bytes are ignored. `miso` stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low when not selected |

## Verification
The bench drives the opcode bit that doubles as A8 both set and clear on neighbouring addresses. A decoder that did not mask that bit would reject 0x0A/0x0B. A decoder that dropped it would alias 0x120 onto 0x020. The bench also writes past the end of a page, ends a write on a partial byte, and reads across address 511. A design that carried into the next page, committed partial writes, or stopped at the top of the array would return wrong bytes. The bench issues commands inside the busy window and checks both protect levels. A design that let a read or a clear through while busy, or that wrote into a fenced page, would show it in the returned status and data.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam int EE_ADDR_W  = 9;
  localparam int EE_DEPTH   = 1 << EE_ADDR_W;
  localparam int EE_DEPTH_W = EE_ADDR_W + 1;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // opcode bit that carries address bit 8 on array commands
  localparam logic [7:0] OP_A8_BIT = 8'h08;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_RSTAT,
    ST_WSTAT,
    ST_DROP
  } ee_state_e;

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  output logic       cs_start_o,
  output logic       cs_end_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       on_boundary_o,
  output logic       miso_o
);

  logic [SYNC_STAGES-1:0] sclk_pipe, cs_pipe, mosi_pipe;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s, mosi_s, sel;
  logic sclk_rise, sclk_fall;

  logic [2:0] bit_cnt_q, bit_cnt_n;
  logic [6:0] rx_sr_q, rx_sr_n;
  logic [7:0] tx_sr_q, tx_sr_n;
  logic       miso_q, miso_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
    end else begin
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk_i};
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n_i};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
      sclk_d    <= sclk_pipe[SYNC_STAGES-1];
      cs_d      <= cs_pipe[SYNC_STAGES-1];
    end
  end

  assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
  assign cs_s      = cs_pipe[SYNC_STAGES-1];
  assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
  assign sel       = ~cs_s;
  assign sclk_rise = sel & sclk_s & ~sclk_d;
  assign sclk_fall = sel & ~sclk_s & sclk_d;

  assign cs_start_o    = ~cs_s & cs_d;
  assign cs_end_o      = cs_s & ~cs_d;
  assign byte_done_o   = sclk_rise & (bit_cnt_q == 3'd7);
  assign rx_byte_o     = {rx_sr_q, mosi_s};
  assign on_boundary_o = (bit_cnt_q == 3'd0);
  assign miso_o        = miso_q;

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    rx_sr_n   = rx_sr_q;
    tx_sr_n   = tx_sr_q;
    miso_n    = miso_q;
    if (cs_start_o) begin
      bit_cnt_n = 3'd0;
    end else if (sclk_rise) begin
      bit_cnt_n = bit_cnt_q + 3'd1;
      rx_sr_n   = {rx_sr_q[5:0], mosi_s};
    end
    if (!sel) begin
      tx_sr_n = 8'h00;
      miso_n  = 1'b0;
    end else if (tx_load_i) begin
      tx_sr_n = tx_data_i;
    end else if (sclk_fall) begin
      miso_n  = tx_sr_q[7];
      tx_sr_n = {tx_sr_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= 3'd0;
      rx_sr_q   <= 7'd0;
      tx_sr_q   <= 8'h00;
      miso_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_n;
      rx_sr_q   <= rx_sr_n;
      tx_sr_q   <= tx_sr_n;
      miso_q    <= miso_n;
    end
  end

  // a completed byte always leaves the bit counter on a boundary
  assert_byte_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |=> on_boundary_o);

  // deselect silences the output line
  assert_idle_miso_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !miso_o);

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = EE_ADDR_W - PAGE_W
) (
  input  logic                    clk,
  input  logic [EE_ADDR_W-1:0]    rd_addr_i,
  output logic [7:0]              rd_data_o,
  input  logic                    commit_i,
  input  logic [BASE_W-1:0]       commit_base_i,
  input  logic [PAGE_BYTES*8-1:0] commit_data_i,
  input  logic [PAGE_BYTES-1:0]   commit_mask_i,
  input  logic [2:0]              bp_i
);

  logic [7:0] mem [EE_DEPTH];

  logic [EE_ADDR_W-1:0]  base_addr;
  logic [EE_DEPTH_W-1:0] limit;
  logic                  prot;

  always_comb begin
    base_addr = {commit_base_i, {PAGE_W{1'b0}}};
    limit     = EE_DEPTH_W'(EE_DEPTH) - (EE_DEPTH_W'(EE_DEPTH) >> (3'd7 - bp_i));
    prot      = (bp_i != 3'd0) && ({1'b0, base_addr} >= limit);
  end

  always_ff @(posedge clk) begin
    if (commit_i && !prot) begin
      for (int g = 0; g < PAGE_BYTES; g++) begin
        if (commit_mask_i[g]) begin
          mem[{commit_base_i, PAGE_W'(g)}] <= commit_data_i[g*8 +: 8];
        end
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 2000,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = EE_ADDR_W - PAGE_W,
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_start_i,
  input  logic                    cs_end_i,
  input  logic                    byte_done_i,
  input  logic [7:0]              rx_byte_i,
  input  logic                    on_boundary_i,
  output logic                    tx_load_o,
  output logic [7:0]              tx_data_o,
  output logic [EE_ADDR_W-1:0]    rd_addr_o,
  input  logic [7:0]              rd_data_i,
  output logic                    commit_o,
  output logic [BASE_W-1:0]       commit_base_o,
  output logic [PAGE_BYTES*8-1:0] commit_data_o,
  output logic [PAGE_BYTES-1:0]   commit_mask_o,
  output logic [2:0]              bp_o
);

  ee_state_e state_q, state_n;
  logic                 a8_q, a8_n;
  logic                 is_rd_q, is_rd_n;
  logic [EE_ADDR_W-1:0] rd_ptr_q, rd_ptr_n;
  logic [BASE_W-1:0]    pg_base_q, pg_base_n;
  logic [PAGE_W-1:0]    pg_off_q, pg_off_n;
  logic [7:0]           pg_data_q [PAGE_BYTES];
  logic [7:0]           pg_data_n [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pg_mask_q, pg_mask_n;
  logic                 wel_q, wel_n;
  logic                 wpen_q, wpen_n;
  logic [2:0]           bp_q, bp_n;
  logic [3:0]           sr_pend_q, sr_pend_n;
  logic                 sr_have_q, sr_have_n;
  logic [CNT_W-1:0]     busy_cnt_q, busy_cnt_n;

  logic                 busy;
  logic [7:0]           status;
  logic [EE_ADDR_W-1:0] addr_full;
  logic [7:0]           op_masked;
  logic                 page_commit, stat_commit;

  assign busy      = (busy_cnt_q != '0);
  assign status    = {wpen_q, 2'b00, bp_q, wel_q, busy};
  assign addr_full = {a8_q, rx_byte_i};
  assign op_masked = rx_byte_i & ~OP_A8_BIT;
  assign rd_addr_o = (state_q == ST_ADDR) ? addr_full : rd_ptr_q;

  always_comb begin
    state_n    = state_q;
    a8_n       = a8_q;
    is_rd_n    = is_rd_q;
    rd_ptr_n   = rd_ptr_q;
    pg_base_n  = pg_base_q;
    pg_off_n   = pg_off_q;
    pg_data_n  = pg_data_q;
    pg_mask_n  = pg_mask_q;
    wel_n      = wel_q;
    wpen_n     = wpen_q;
    bp_n       = bp_q;
    sr_pend_n  = sr_pend_q;
    sr_have_n  = sr_have_q;
    busy_cnt_n = busy_cnt_q;
    tx_load_o  = 1'b0;
    tx_data_o  = 8'h00;
    page_commit = 1'b0;
    stat_commit = 1'b0;

    if (busy) begin
      busy_cnt_n = busy_cnt_q - CNT_W'(1);
      if (busy_cnt_q == CNT_W'(1)) wel_n = 1'b0;
    end

    if (cs_start_i) begin
      state_n = ST_OPC;
    end else if (cs_end_i) begin
      state_n     = ST_IDLE;
      page_commit = (state_q == ST_WDATA) && on_boundary_i && (pg_mask_q != '0);
      stat_commit = (state_q == ST_WSTAT) && on_boundary_i && sr_have_q;
      if (page_commit || stat_commit) busy_cnt_n = CNT_W'(BUSY_CYCLES);
      if (stat_commit) begin
        wpen_n = sr_pend_q[3];
        bp_n   = sr_pend_q[2:0];
      end
    end else if (byte_done_i) begin
      case (state_q)
        ST_OPC: begin
          state_n = ST_DROP;
          if (rx_byte_i == OP_RDSR) begin
            tx_load_o = 1'b1;
            tx_data_o = status;
            state_n   = ST_RSTAT;
          end else if (!busy) begin
            if (rx_byte_i == OP_WREN) begin
              wel_n = 1'b1;
            end else if (rx_byte_i == OP_WRDI) begin
              wel_n = 1'b0;
            end else if (rx_byte_i == OP_WRSR) begin
              sr_have_n = 1'b0;
              if (wel_q) state_n = ST_WSTAT;
            end else if (op_masked == OP_READ) begin
              a8_n    = rx_byte_i[3];
              is_rd_n = 1'b1;
              state_n = ST_ADDR;
            end else if (op_masked == OP_WRITE) begin
              a8_n    = rx_byte_i[3];
              is_rd_n = 1'b0;
              if (wel_q) state_n = ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (is_rd_q) begin
            tx_load_o = 1'b1;
            tx_data_o = rd_data_i;
            rd_ptr_n  = addr_full + EE_ADDR_W'(1);
            state_n   = ST_RDATA;
          end else begin
            pg_base_n = addr_full[EE_ADDR_W-1:PAGE_W];
            pg_off_n  = addr_full[PAGE_W-1:0];
            pg_mask_n = '0;
            state_n   = ST_WDATA;
          end
        end
        ST_RDATA: begin
          tx_load_o = 1'b1;
          tx_data_o = rd_data_i;
          rd_ptr_n  = rd_ptr_q + EE_ADDR_W'(1);
        end
        ST_RSTAT: begin
          tx_load_o = 1'b1;
          tx_data_o = status;
        end
        ST_WDATA: begin
          pg_data_n[pg_off_q] = rx_byte_i;
          pg_mask_n[pg_off_q] = 1'b1;
          pg_off_n            = pg_off_q + PAGE_W'(1);
        end
        ST_WSTAT: begin
          sr_pend_n = {rx_byte_i[7], rx_byte_i[4:2]};
          sr_have_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      a8_q       <= 1'b0;
      is_rd_q    <= 1'b0;
      rd_ptr_q   <= '0;
      pg_base_q  <= '0;
      pg_off_q   <= '0;
      pg_mask_q  <= '0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      bp_q       <= 3'd0;
      sr_pend_q  <= 4'd0;
      sr_have_q  <= 1'b0;
      busy_cnt_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pg_data_q[i] <= 8'h00;
    end else begin
      state_q    <= state_n;
      a8_q       <= a8_n;
      is_rd_q    <= is_rd_n;
      rd_ptr_q   <= rd_ptr_n;
      pg_base_q  <= pg_base_n;
      pg_off_q   <= pg_off_n;
      pg_mask_q  <= pg_mask_n;
      wel_q      <= wel_n;
      wpen_q     <= wpen_n;
      bp_q       <= bp_n;
      sr_pend_q  <= sr_pend_n;
      sr_have_q  <= sr_have_n;
      busy_cnt_q <= busy_cnt_n;
      pg_data_q  <= pg_data_n;
    end
  end

  assign commit_o      = page_commit;
  assign commit_base_o = pg_base_q;
  assign commit_mask_o = pg_mask_q;
  assign bp_o          = bp_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign commit_data_o[g*8 +: 8] = pg_data_q[g];
  end

  assert_commit_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> wel_q);

  assert_commit_starts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> busy);

  assert_wel_drops_at_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt_q == CNT_W'(1)) |=> !wel_q);

  assert_busy_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_done_i && !cs_start_i && !cs_end_i && state_q == ST_OPC
     && rx_byte_i != OP_RDSR) |=> (state_q == ST_DROP));

  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && !cs_start_i && !cs_end_i && state_q == ST_WDATA
     && pg_off_q == '1) |=> (pg_off_q == '0));

endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = EE_ADDR_W - PAGE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic                    cs_start, cs_end, byte_done, on_boundary;
  logic [7:0]              rx_byte;
  logic                    tx_load;
  logic [7:0]              tx_data;
  logic [EE_ADDR_W-1:0]    rd_addr;
  logic [7:0]              rd_data;
  logic                    commit;
  logic [BASE_W-1:0]       commit_base;
  logic [PAGE_BYTES*8-1:0] commit_data;
  logic [PAGE_BYTES-1:0]   commit_mask;
  logic [2:0]              bp;

  spi_ee_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sclk_i       (sclk),
    .cs_n_i       (cs_n),
    .mosi_i       (mosi),
    .tx_load_i    (tx_load),
    .tx_data_i    (tx_data),
    .cs_start_o   (cs_start),
    .cs_end_o     (cs_end),
    .byte_done_o  (byte_done),
    .rx_byte_o    (rx_byte),
    .on_boundary_o(on_boundary),
    .miso_o       (miso)
  );

  spi_ee_ctrl #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cs_start_i   (cs_start),
    .cs_end_i     (cs_end),
    .byte_done_i  (byte_done),
    .rx_byte_i    (rx_byte),
    .on_boundary_i(on_boundary),
    .tx_load_o    (tx_load),
    .tx_data_o    (tx_data),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (rd_data),
    .commit_o     (commit),
    .commit_base_o(commit_base),
    .commit_data_o(commit_data),
    .commit_mask_o(commit_mask),
    .bp_o         (bp)
  );

  spi_ee_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk          (clk),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .commit_i     (commit),
    .commit_base_i(commit_base),
    .commit_data_i(commit_data),
    .commit_mask_i(commit_mask),
    .bp_i         (bp)
  );

endmodule

// File: tb/tb_spi_eeprom.sv
module tb_spi_eeprom;

  localparam int BUSY = 1500;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso;

  always #5 clk = ~clk;

  spi_eeprom #(.PAGE_BYTES(8), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       exp_q[$];
  int         vectors = 0;
  int         misses  = 0;
  logic       listen  = 1'b0;
  int         mon_cnt = 0;
  logic [7:0] mon_sr  = 8'h00;

  logic [7:0] model [512];
  logic       wel_m = 1'b0;
  logic [2:0] bp_m  = 3'd0;
  logic [7:0] wbuf [8];

  // monitor: assembles bytes from miso on host sampling edges
  always @(posedge sclk) begin
    if (listen) begin
      mon_sr = {mon_sr[6:0], miso};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) begin
          misses++;
          $display("FAIL unexpected byte: got %02h expected none", mon_sr);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          vectors++;
          if (mon_sr !== e.val) begin
            misses++;
            $display("FAIL %s: got %02h expected %02h", e.req, mon_sr, e.val);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    mosi = b;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(4 * HALF);
  endtask

  task automatic start_listen();
    mon_cnt = 0;
    listen  = 1'b1;
  endtask

  function automatic bit prot_m(input int a);
    if (bp_m == 3'd0) return 1'b0;
    return a >= (512 - (512 >> (7 - bp_m)));
  endfunction

  task automatic cmd1(input logic [7:0] op);
    cs_on();
    byte_out(op);
    cs_off();
  endtask

  task automatic rdsr_chk(input logic [7:0] e, input string r);
    cs_on();
    byte_out(8'h05);
    exp_q.push_back('{e, r});
    start_listen();
    byte_out(8'h00);
    listen = 1'b0;
    cs_off();
  endtask

  task automatic read_chk(input int a, input int n, input string r);
    cs_on();
    byte_out({4'b0000, a[8], 3'b011});
    byte_out(a[7:0]);
    for (int i = 0; i < n; i++) exp_q.push_back('{model[(a + i) % 512], r});
    start_listen();
    for (int i = 0; i < n; i++) byte_out(8'h00);
    listen = 1'b0;
    cs_off();
  endtask

  // command byte (and optional argument) then one byte that must read as zero
  task automatic quiet_chk(input logic [7:0] op, input bit has_arg, input logic [7:0] arg,
                           input string r);
    cs_on();
    byte_out(op);
    if (has_arg) byte_out(arg);
    exp_q.push_back('{8'h00, r});
    start_listen();
    byte_out(8'h00);
    listen = 1'b0;
    cs_off();
  endtask

  task automatic write_page(input int a, input int n);
    cs_on();
    byte_out({4'b0000, a[8], 3'b010});
    byte_out(a[7:0]);
    for (int i = 0; i < n; i++) byte_out(wbuf[i]);
    cs_off();
    if (wel_m) begin
      for (int i = 0; i < n; i++) begin
        int t;
        t = (a & ~7) | ((a + i) & 7);
        if (!prot_m(t)) model[t] = wbuf[i];
      end
    end
  endtask

  task automatic write_status(input logic [7:0] v);
    cs_on();
    byte_out(8'h01);
    byte_out(v);
    cs_off();
  endtask

  task automatic settle();
    tick(BUSY + 200);
    wel_m = 1'b0;
  endtask

  task automatic fill(input logic [7:0] first);
    for (int i = 0; i < 8; i++) wbuf[i] = first + 8'(i);
  endtask

  task automatic full_write(input int a, input int n, input logic [7:0] first);
    fill(first);
    cmd1(8'h06);
    wel_m = 1'b1;
    write_page(a, n);
    settle();
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      misses++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    tick(190000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    cs_n  = 1'b1;
    sclk  = 1'b0;
    mosi  = 1'b0;
    rst_n = 1'b0;
    tick(5);
    vectors++;
    if (miso !== 1'b0) begin
      misses++;
      $display("FAIL R1 miso in reset: got %b expected 0", miso);
    end
    rst_n = 1'b1;
    tick(10);

    // R1 reset status
    rdsr_chk(8'h00, "R1 status after reset");

    // R2 enable flag set and clear
    cmd1(8'h06);
    rdsr_chk(8'h02, "R2 enable set");
    cmd1(8'h04);
    rdsr_chk(8'h00, "R2 enable cleared");

    // R8/R9 commit, busy window
    fill(8'h11);
    cmd1(8'h06);
    wel_m = 1'b1;
    write_page(16, 8);
    rdsr_chk(8'h03, "R8 busy after commit");
    quiet_chk(8'h03, 1'b1, 8'h10, "R9 read ignored while busy");
    cmd1(8'h04);
    rdsr_chk(8'h03, "R9 clear ignored while busy");
    settle();
    rdsr_chk(8'h00, "R8 ready and enable cleared");

    // R3 plain read
    read_chk(16, 8, "R3 read page 0x010");

    // R3 A8 carried in opcode bit 3
    full_write(32, 3, 8'h21);
    full_write(288, 3, 8'hA1);
    read_chk(288, 3, "R3 read with A8 set");
    read_chk(32, 3, "R3 read with A8 clear");

    // R6 wrap inside page
    full_write(48, 8, 8'h30);
    full_write(54, 4, 8'hC1);
    read_chk(48, 8, "R6 in-page wrap");

    // R7 partial final byte drops the write
    cmd1(8'h06);
    cs_on();
    byte_out(8'h02);
    byte_out(8'h30);
    byte_out(8'hEE);
    bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    cs_off();
    rdsr_chk(8'h02, "R7 no commit, enable kept");
    read_chk(48, 8, "R7 array unchanged");
    cmd1(8'h04);

    // R4 read wraps past the top
    full_write(504, 8, 8'hF0);
    full_write(0, 8, 8'h80);
    read_chk(510, 4, "R4 wrap 511 to 0");

    // R5 write without enable
    fill(8'h55);
    wel_m = 1'b0;
    write_page(16, 8);
    rdsr_chk(8'h00, "R5 no busy without enable");
    read_chk(16, 8, "R5 array unchanged");
    write_status(8'h9C);
    rdsr_chk(8'h00, "R5 status write without enable");

    // R10 status write: all ones
    cmd1(8'h06);
    write_status(8'hFF);
    rdsr_chk(8'h9F, "R10 status during busy");
    settle();
    bp_m = 3'd7;
    rdsr_chk(8'h9C, "R10 writable bits only");

    // R11 whole array fenced
    full_write(16, 8, 8'h66);
    read_chk(16, 8, "R11 level 7 drops write");

    // R11 level 1 fences the top page only
    cmd1(8'h06);
    write_status(8'h04);
    settle();
    bp_m = 3'd1;
    rdsr_chk(8'h04, "R10 level 1 stored");
    full_write(504, 8, 8'h70);
    full_write(496, 8, 8'h78);
    read_chk(496, 16, "R11 top page fenced, next page written");

    // R12 unknown commands
    quiet_chk(8'h07, 1'b0, 8'h00, "R12 opcode 0x07 silent");
    quiet_chk(8'h0E, 1'b1, 8'h00, "R12 opcode 0x0E silent");
    rdsr_chk(8'h04, "R12 status unchanged");

    tick(20);
    finish_run();
  end

endmodule